// File: doc/BRIEF.md
# Narrow-Access Register Window Adapter

This block sits between a host I/O port and register banks that only take full 32-bit words. It serves a 128-byte window. The host may read or write 1, 2, 3 or 4 bytes at any byte offset in the window. The window is decoded into three targets: a bank of sixteen words for the SCSI core, a bank of eight words for the DMA engine, and one bus-control word. The adapter stores the bus-control word itself.

The banks are addressed by word index and have a combinational read port and a write strobe. A write of four bytes at an aligned offset goes straight to the bank.

Any narrower or unaligned write is converted into a full-word write:
- The adapter first reads the current word from the bank.
- It places the new bytes over that word, little-endian.
- It writes the result back to the aligned word.

A read always fetches the aligned word. The adapter then shifts it down to the requested byte and masks it to the requested size. Offsets that decode to nothing behave differently for the two directions: reads of them return zero, and writes to them are discarded.

Top module: `reg_window_adapter`

## Requirements
- R1: While rst_ni is low, busy_o, rvalid_o and every bank strobe are 0, and bus_ctl_o is 0.
- R2: Offsets 0x00-0x3F select the core bank at word index offset>>2.
- R3: Offsets 0x40-0x5F select the DMA bank at word index (offset-0x40)>>2.
- R4: The word at offset 0x70 is the bus-control register. It is readable and writable through the window, including with narrow accesses, and its value drives bus_ctl_o. It changes only because of a write to it.
- R5: A 4-byte write at an aligned offset produces exactly one bank write strobe, in the cycle after the request, carrying wdata_i unchanged. It raises no read strobe and does not raise busy_o.
- R6: A write narrower than 4 bytes, or at an unaligned offset, raises a read strobe and busy_o in the cycle after the request. It raises the write strobe in the cycle after that. Byte offset k of the word sits on bits 8k+7:8k. Write byte j lands on lane (offset&3)+j. Bytes outside the written lanes keep their old value. Bytes that would land beyond lane 3 are discarded.
- R7: A read raises a read strobe and busy_o in the cycle after the request. rvalid_o pulses in the following cycle, with rdata_o equal to the aligned word shifted right by (offset&3)×8 and masked to size×8 bits.
- R8: A read of an offset that maps to no target (0x60-0x6F and 0x74-0x7F) returns 0.
- R9: A write to an offset that maps to no target raises no bank strobe and leaves every bank and the bus-control word unchanged.
- R10: At most one of the four bank strobes is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 7 | Byte offset in the window |
| size_i | input | 3 | Access size in bytes, 1 to 4 |
| wdata_i | input | 32 | Write bytes, lowest byte first |
| busy_o | output | 1 | Adapter is fetching; host must hold off |
| rvalid_o | output | 1 | Read result valid pulse |
| rdata_o | output | 32 | Read result, zero-extended |
| bus_ctl_o | output | 32 | Current bus-control word |
| core_re_o | output | 1 | Core bank read strobe |
| core_we_o | output | 1 | Core bank write strobe |
| core_idx_o | output | 4 | Core bank word index |
| core_wdata_o | output | 32 | Core bank write word |
| core_rdata_i | input | 32 | Core bank word at core_idx_o |
| dma_re_o | output | 1 | DMA bank read strobe |
| dma_we_o | output | 1 | DMA bank write strobe |
| dma_idx_o | output | 3 | DMA bank word index |
| dma_wdata_o | output | 32 | DMA bank write word |
| dma_rdata_i | input | 32 | DMA bank word at dma_idx_o |

## Verification
The assertions assume the host respects two input rules:
- It never presents req_i while busy_o is high.
- Every request carries a size between 1 and 4.

Under those rules each accepted access produces exactly one result: a single bank write, or a single rvalid_o pulse, or, for an unmapped write, nothing. The stimulus driver keeps to both rules. It releases req_i after one cycle, waits on busy_o before its next access, and only issues legal sizes. It still covers every alignment, size and region, including the lane-3 overflow case and the unmapped holes.

// File: rtl/rwa_pkg.sv
`timescale 1ns/1ps
package rwa_pkg;
  typedef enum logic [1:0] {
    RGN_CORE,
    RGN_DMA,
    RGN_BCTL,
    RGN_NONE
  } rgn_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RD,
    ST_FETCH,
    ST_WR
  } st_e;
endpackage

// File: rtl/rwa_decode.sv
`timescale 1ns/1ps
module rwa_decode
  import rwa_pkg::*;
#(
  parameter int ADDR_W     = 7,
  parameter int BYTES      = 4,
  parameter int CORE_WORDS = 16,
  parameter int DMA_BASE   = 64,
  parameter int DMA_WORDS  = 8,
  parameter int BCTL_OFF   = 112,
  parameter int CORE_IDX_W = 4,
  parameter int DMA_IDX_W  = 3
) (
  input  logic [ADDR_W-1:0]     addr_i,
  output rgn_e                  rgn_o,
  output logic [CORE_IDX_W-1:0] core_idx_o,
  output logic [DMA_IDX_W-1:0]  dma_idx_o
);
  localparam int OFF_W    = $clog2(BYTES);
  localparam int CORE_END = CORE_WORDS * BYTES;
  localparam int DMA_END  = DMA_BASE + DMA_WORDS * BYTES;

  int aln;

  always_comb begin
    aln = (int'(addr_i) >> OFF_W) << OFF_W;
    if (aln < CORE_END)                         rgn_o = RGN_CORE;
    else if (aln >= DMA_BASE && aln < DMA_END)  rgn_o = RGN_DMA;
    else if (aln == BCTL_OFF)                   rgn_o = RGN_BCTL;
    else                                        rgn_o = RGN_NONE;
  end

  assign core_idx_o = CORE_IDX_W'(int'(addr_i) >> OFF_W);
  assign dma_idx_o  = DMA_IDX_W'((int'(addr_i) - DMA_BASE) >> OFF_W);
endmodule

// File: rtl/rwa_lanes.sv
`timescale 1ns/1ps
module rwa_lanes #(
  parameter int DATA_W = 32,
  parameter int OFF_W  = 2,
  parameter int SIZE_W = 3
) (
  input  logic [DATA_W-1:0] cur_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic [DATA_W-1:0] merged_o,
  output logic [DATA_W-1:0] rd_o
);
  localparam int BYTES = DATA_W / 8;

  logic [DATA_W-1:0] rd_shift;
  assign rd_shift = cur_i >> (8 * int'(off_i));

  // lane k takes write byte (k - off) when inside the window; little-endian
  for (genvar k = 0; k < BYTES; k++) begin : g_lane
    logic              in_win;
    logic [DATA_W-1:0] src;
    assign in_win = (k >= int'(off_i)) && (k < int'(off_i) + int'(size_i));
    assign src    = wdata_i >> (8 * (k - int'(off_i)));
    assign merged_o[8*k +: 8] = in_win ? src[7:0] : cur_i[8*k +: 8];
    assign rd_o[8*k +: 8]     = (k < int'(size_i)) ? rd_shift[8*k +: 8] : 8'h00;
  end
endmodule

// File: rtl/reg_window_adapter.sv
`timescale 1ns/1ps
module reg_window_adapter
  import rwa_pkg::*;
#(
  parameter int ADDR_W     = 7,
  parameter int DATA_W     = 32,
  parameter int CORE_WORDS = 16,
  parameter int DMA_BASE   = 64,
  parameter int DMA_WORDS  = 8,
  parameter int BCTL_OFF   = 112,
  localparam int BYTES      = DATA_W / 8,
  localparam int OFF_W      = $clog2(BYTES),
  localparam int SIZE_W     = OFF_W + 1,
  localparam int CORE_IDX_W = $clog2(CORE_WORDS),
  localparam int DMA_IDX_W  = $clog2(DMA_WORDS)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_i,
  input  logic                  we_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [SIZE_W-1:0]     size_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output logic                  busy_o,
  output logic                  rvalid_o,
  output logic [DATA_W-1:0]     rdata_o,
  output logic [DATA_W-1:0]     bus_ctl_o,
  output logic                  core_re_o,
  output logic                  core_we_o,
  output logic [CORE_IDX_W-1:0] core_idx_o,
  output logic [DATA_W-1:0]     core_wdata_o,
  input  logic [DATA_W-1:0]     core_rdata_i,
  output logic                  dma_re_o,
  output logic                  dma_we_o,
  output logic [DMA_IDX_W-1:0]  dma_idx_o,
  output logic [DATA_W-1:0]     dma_wdata_o,
  input  logic [DATA_W-1:0]     dma_rdata_i
);
  st_e               st_q, st_d;
  logic [ADDR_W-1:0] addr_q;
  logic [SIZE_W-1:0] size_q;
  logic [DATA_W-1:0] wword_q;
  logic [DATA_W-1:0] rdata_q;
  logic              rvalid_q;
  logic [DATA_W-1:0] bctl_q;

  rgn_e              rgn;
  logic [DATA_W-1:0] cur_word, merged, rd_ext;
  logic              accept, narrow, rd_phase, wr_phase;

  rwa_decode #(
    .ADDR_W(ADDR_W), .BYTES(BYTES), .CORE_WORDS(CORE_WORDS),
    .DMA_BASE(DMA_BASE), .DMA_WORDS(DMA_WORDS), .BCTL_OFF(BCTL_OFF),
    .CORE_IDX_W(CORE_IDX_W), .DMA_IDX_W(DMA_IDX_W)
  ) u_dec (
    .addr_i    (addr_q),
    .rgn_o     (rgn),
    .core_idx_o(core_idx_o),
    .dma_idx_o (dma_idx_o)
  );

  always_comb begin
    unique case (rgn)
      RGN_CORE: cur_word = core_rdata_i;
      RGN_DMA:  cur_word = dma_rdata_i;
      RGN_BCTL: cur_word = bctl_q;
      default:  cur_word = '0;
    endcase
  end

  rwa_lanes #(.DATA_W(DATA_W), .OFF_W(OFF_W), .SIZE_W(SIZE_W)) u_lanes (
    .cur_i   (cur_word),
    .wdata_i (wword_q),
    .off_i   (addr_q[OFF_W-1:0]),
    .size_i  (size_q),
    .merged_o(merged),
    .rd_o    (rd_ext)
  );

  assign rd_phase = (st_q == ST_RD) || (st_q == ST_FETCH);
  assign wr_phase = (st_q == ST_WR);
  assign busy_o   = rd_phase;
  assign accept   = req_i && !busy_o;
  assign narrow   = (size_i != SIZE_W'(BYTES)) || (addr_i[OFF_W-1:0] != '0);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE, ST_WR: begin
        if (!accept)    st_d = ST_IDLE;
        else if (!we_i) st_d = ST_RD;
        else if (narrow) st_d = ST_FETCH;
        else            st_d = ST_WR;
      end
      ST_RD:    st_d = ST_IDLE;
      ST_FETCH: st_d = ST_WR;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      addr_q   <= '0;
      size_q   <= '0;
      wword_q  <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
      bctl_q   <= '0;
    end else begin
      st_q     <= st_d;
      rvalid_q <= (st_q == ST_RD);
      if (st_q == ST_RD)    rdata_q <= rd_ext;
      if (st_q == ST_FETCH) wword_q <= merged;
      if (wr_phase && rgn == RGN_BCTL) bctl_q <= wword_q;
      if (accept && (st_q == ST_IDLE || st_q == ST_WR)) begin
        addr_q  <= addr_i;
        size_q  <= size_i;
        wword_q <= wdata_i;
      end
    end
  end

  assign core_re_o    = rd_phase && (rgn == RGN_CORE);
  assign dma_re_o     = rd_phase && (rgn == RGN_DMA);
  assign core_we_o    = wr_phase && (rgn == RGN_CORE);
  assign dma_we_o     = wr_phase && (rgn == RGN_DMA);
  assign core_wdata_o = wword_q;
  assign dma_wdata_o  = wword_q;
  assign rvalid_o     = rvalid_q;
  assign rdata_o      = rdata_q;
  assign bus_ctl_o    = bctl_q;
endmodule

// File: rtl/rwa_checker.sv
`timescale 1ns/1ps
module rwa_checker #(
  parameter int DATA_W = 32,
  parameter int SIZE_W = 3,
  parameter int BYTES  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [SIZE_W-1:0] size_i,
  input logic              busy_o,
  input logic              rvalid_o,
  input logic [DATA_W-1:0] bus_ctl_o,
  input logic              core_re_o,
  input logic              core_we_o,
  input logic              dma_re_o,
  input logic              dma_we_o
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_quiet_r1: assert (!busy_o && !rvalid_o && !core_re_o && !core_we_o
                                && !dma_re_o && !dma_we_o && bus_ctl_o == '0);
    end
  end

  p_strobe_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({core_re_o, core_we_o, dma_re_o, dma_we_o}));

  // input rules the host must keep
  p_no_req_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !req_i);

  p_size_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |-> (size_i != '0) && (int'(size_i) <= BYTES));

  p_busy_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !busy_o);

  p_rvalid_after_fetch_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> $past(busy_o) && !core_we_o && !dma_we_o);

  p_write_origin_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_we_o || dma_we_o) |-> $past(req_i && we_i && !busy_o) || $past(busy_o));

  p_bctl_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(bus_ctl_o) |-> $past(req_i && we_i && !busy_o, 2) || $past(busy_o, 2));
endmodule

bind reg_window_adapter rwa_checker #(
  .DATA_W(DATA_W), .SIZE_W(SIZE_W), .BYTES(BYTES)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .we_i     (we_i),
  .size_i   (size_i),
  .busy_o   (busy_o),
  .rvalid_o (rvalid_o),
  .bus_ctl_o(bus_ctl_o),
  .core_re_o(core_re_o),
  .core_we_o(core_we_o),
  .dma_re_o (dma_re_o),
  .dma_we_o (dma_we_o)
);

// File: tb/sim_reg_window_adapter.sv
`timescale 1ns/1ps
module sim_reg_window_adapter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        req = 1'b0, we = 1'b0;
  logic [6:0]  addr = '0;
  logic [2:0]  size = '0;
  logic [31:0] wdata = '0;
  logic        busy, rvalid;
  logic [31:0] rdata, bctl;
  logic        core_re, core_we, dma_re, dma_we;
  logic [3:0]  core_idx;
  logic [2:0]  dma_idx;
  logic [31:0] core_wdata, dma_wdata, core_rdata, dma_rdata;

  logic [31:0] core_mem [16];
  logic [31:0] dma_mem  [8];
  logic [31:0] sh_core  [16];
  logic [31:0] sh_dma   [8];
  logic [31:0] sh_bctl = '0;

  int          q_kind[$];
  int          q_idx[$];
  logic [31:0] q_data[$];
  string       q_tag[$];
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  reg_window_adapter u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .size_i(size), .wdata_i(wdata), .busy_o(busy), .rvalid_o(rvalid),
    .rdata_o(rdata), .bus_ctl_o(bctl),
    .core_re_o(core_re), .core_we_o(core_we), .core_idx_o(core_idx),
    .core_wdata_o(core_wdata), .core_rdata_i(core_rdata),
    .dma_re_o(dma_re), .dma_we_o(dma_we), .dma_idx_o(dma_idx),
    .dma_wdata_o(dma_wdata), .dma_rdata_i(dma_rdata)
  );

  assign core_rdata = core_mem[core_idx];
  assign dma_rdata  = dma_mem[dma_idx];
  always @(posedge clk) begin
    if (core_we) core_mem[core_idx] <= core_wdata;
    if (dma_we)  dma_mem[dma_idx]   <= dma_wdata;
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] sh_word(input int al);
    if (al < 64)       return sh_core[al >> 2];
    else if (al < 96)  return sh_dma[(al - 64) >> 2];
    else if (al == 112) return sh_bctl;
    return '0;
  endfunction

  task automatic push(input int kind, input int idx, input logic [31:0] d, input string tag);
    q_kind.push_back(kind); q_idx.push_back(idx); q_data.push_back(d); q_tag.push_back(tag);
  endtask

  task automatic issue(input bit w, input int a, input int sz, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = w; addr = a[6:0]; size = sz[2:0]; wdata = d;
    @(negedge clk);
    req = 1'b0;
    while (busy) @(negedge clk);
  endtask

  task automatic host_write(input int a, input int sz, input logic [31:0] d, input string tag);
    int al, off;
    logic [31:0] m;
    al = a & ~3; off = a & 3;
    m = sh_word(al);
    for (int k = 0; k < 4; k++)
      if (k >= off && k < off + sz) m[8*k +: 8] = d[8*(k-off) +: 8];
    if (al < 64) begin
      push(0, al >> 2, m, tag); sh_core[al >> 2] = m;
    end else if (al < 96) begin
      push(1, (al - 64) >> 2, m, tag); sh_dma[(al - 64) >> 2] = m;
    end else if (al == 112) sh_bctl = m;
    issue(1'b1, a, sz, d);
  endtask

  task automatic host_read(input int a, input int sz, input string tag);
    logic [31:0] e;
    e = sh_word(a & ~3) >> (8 * (a & 3));
    if (sz < 4) e = e & ((32'h1 << (8 * sz)) - 32'h1);
    push(2, 0, e, tag);
    issue(1'b0, a, sz, 32'h0);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (core_we || dma_we || rvalid) begin
        int kind, idx;
        logic [31:0] d;
        string tag;
        kind = core_we ? 0 : (dma_we ? 1 : 2);
        idx  = core_we ? int'(core_idx) : (dma_we ? int'(dma_idx) : 0);
        d    = core_we ? core_wdata : (dma_we ? dma_wdata : rdata);
        if (q_kind.size() == 0) begin
          check(1'b0, "R9", "unexpected bank write or read result", 32'(kind), 32'hffffffff);
        end else begin
          int ek, ei;
          logic [31:0] ed;
          ek = q_kind.pop_front(); ei = q_idx.pop_front();
          ed = q_data.pop_front(); tag = q_tag.pop_front();
          check(kind == ek, tag, "result kind", 32'(kind), 32'(ek));
          check(idx == ei, tag, "word index", 32'(idx), 32'(ei));
          check(d == ed, tag, "data", d, ed);
        end
      end
      if (core_re || dma_re || core_we || dma_we)
        check($countones({core_re, core_we, dma_re, dma_we}) == 1, "R10", "strobe overlap",
              32'({core_re, core_we, dma_re, dma_we}), 32'h1);
      if (core_re || dma_re)
        check(busy, "R7", "read strobe without busy", 32'(busy), 32'h1);
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      core_mem[i] = 32'hA0000000 + i * 32'h00010203; sh_core[i] = core_mem[i];
    end
    for (int i = 0; i < 8; i++) begin
      dma_mem[i] = 32'h50000000 + i * 32'h01020304; sh_dma[i] = dma_mem[i];
    end
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busy && !rvalid, "R1", "busy/rvalid in reset", {30'd0, busy, rvalid}, 32'h0);
    check(!core_re && !core_we && !dma_re && !dma_we, "R1", "strobes in reset",
          32'({core_re, core_we, dma_re, dma_we}), 32'h0);
    check(bctl == 32'h0, "R1", "bus-control in reset", bctl, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 / R3 / R5 aligned full words
    host_write(8'h00, 4, 32'h11223344, "R2");
    host_write(8'h3C, 4, 32'hDEADBEEF, "R2");
    host_read (8'h3C, 4, "R2");
    host_write(8'h40, 4, 32'h0BADF00D, "R3");
    host_write(8'h5C, 4, 32'h76543210, "R3");
    host_read (8'h5C, 4, "R3");
    host_write(8'h14, 4, 32'hCAFE1234, "R5");
    // R4 bus-control word
    host_write(8'h70, 4, 32'hCAFEF00D, "R4");
    @(negedge clk);
    check(bctl == sh_bctl, "R4", "bus_ctl_o after full write", bctl, sh_bctl);
    host_read (8'h70, 4, "R4");
    host_read (8'h71, 2, "R4");
    host_write(8'h72, 1, 32'h0000005A, "R4");
    @(negedge clk);
    check(bctl == sh_bctl, "R4", "bus_ctl_o after byte write", bctl, sh_bctl);
    // R6 merged writes
    host_write(8'h15, 1, 32'h000000AB, "R6");
    host_write(8'h22, 2, 32'h0000BEEF, "R6");
    host_write(8'h43, 2, 32'h00001234, "R6");
    host_write(8'h01, 3, 32'h00C0FFEE, "R6");
    host_write(8'h06, 4, 32'h89ABCDEF, "R6");
    host_write(8'h4D, 1, 32'h00000077, "R6");
    // R7 shifted reads
    host_read (8'h15, 1, "R7");
    host_read (8'h22, 2, "R7");
    host_read (8'h01, 3, "R7");
    host_read (8'h06, 4, "R7");
    host_read (8'h43, 1, "R7");
    host_read (8'h4E, 2, "R7");
    host_read (8'h00, 4, "R7");
    // R8 unmapped reads
    host_read (8'h60, 4, "R8");
    host_read (8'h6C, 2, "R8");
    host_read (8'h74, 4, "R8");
    host_read (8'h7F, 1, "R8");
    // R9 unmapped writes
    host_write(8'h64, 4, 32'hFFFFFFFF, "R9");
    host_write(8'h7A, 1, 32'h000000EE, "R9");
    host_write(8'h6F, 1, 32'h00000011, "R9");
    host_read (8'h70, 4, "R9");
    repeat (4) @(negedge clk);
    check(bctl == sh_bctl, "R9", "bus_ctl_o after hole writes", bctl, sh_bctl);
    check(q_kind.size() == 0, "R9", "pending expected items", 32'(q_kind.size()), 32'h0);
    for (int i = 0; i < 16; i++)
      check(core_mem[i] == sh_core[i], "R9", "core bank content", core_mem[i], sh_core[i]);
    for (int i = 0; i < 8; i++)
      check(dma_mem[i] == sh_dma[i], "R9", "dma bank content", dma_mem[i], sh_dma[i]);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule